// File: doc/BRIEF.md
# S/PDIF Channel-Status Block Capture

This block sits after an S/PDIF deframer and gathers the 192-bit channel-status block carried one bit per subframe. Each subframe arrives as a single-cycle strobe. The strobe comes with three things: the subframe's C bit, a flag that tells whether the subframe belongs to channel A or channel B, and a marker that identifies the first frame of a block. A control input picks the channel whose status is collected. Subframes of the other channel are ignored.

Collection runs into a hidden shadow register. The whole block is copied to the readable register only when the 192nd bit of the selected channel is accepted. As a result, software reading through the page-select port always sees one complete, coherent block. A companion mask output marks every status bit as meaningful on each valid page.

Top module: `spdif_cstat_capture`

## Requirements
- R1: After reset, every page of `rd_word` reads 0 and no block collection is in progress.
- R2: A subframe is accepted only when `sub_valid` is 1 at a rising clock edge and `sub_chan_b` equals `chan_sel`, where 0 means channel A and 1 means channel B. Subframes of the other channel have no effect on the captured block.
- R3: Bit k of a block is stored in status byte k/8 at bit position k mod 8. Bit k is the k-th accepted bit, counting from 0 at the accepted subframe that carries `sub_block_start`. Page p (0 to 5) returns status bytes 4p to 4p+3, with byte 4p+j in `rd_word[8j+7:8j]`, so `rd_word` bit i equals block bit 32p+i.
- R4: The readable block changes only on the clock edge that accepts the 192nd bit of a block. It takes all 192 bits on that edge. Before that edge, the previous complete block stays readable.
- R5: An accepted subframe that carries `sub_block_start` while a block is partly collected discards the partial block. That subframe's bit becomes bit 0 of a new block.
- R6: Once a block has completed, accepted subframes without `sub_block_start` are ignored until the next block start.
- R7: A clock cycle in which `chan_sel` differs from its value in the previous cycle discards any partial block. The subframe offered in that cycle is ignored.
- R8: Page-select values 6 and 7 return 0 on both `rd_word` and `rd_mask`.
- R9: For page-select values 0 to 5, `rd_mask` reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | One-cycle strobe, one per decoded subframe |
| sub_chan_b | input | 1 | Subframe channel: 0 = A, 1 = B |
| sub_block_start | input | 1 | Subframe belongs to the first frame of a status block |
| sub_cbit | input | 1 | Channel-status bit of the subframe |
| chan_sel | input | 1 | Channel to capture: 0 = A, 1 = B |
| page_sel | input | 3 | Readback page, 0 to 5 valid |
| rd_word | output | 32 | Captured status word for the selected page |
| rd_mask | output | 32 | Status mask for the selected page |

## Verification
Captured data appears on `rd_word` right after the clock edge that accepts the 192nd selected bit. Readback is combinational in `page_sel`, so a new page is valid in the same cycle. The bench therefore drives each subframe at a falling edge and updates its reference block after the following rising edge. It compares all eight pages just after the next falling edge, leaving 1 ns for the read path to settle after each page change. Mid-block reads, taken before the final bit, confirm that the previous block is still held.

// File: rtl/spdif_cstat_capture.sv
module spdif_cstat_capture #(
  parameter int BLOCK_BITS = 192,
  parameter int WORD_W     = 32,
  parameter int PAGE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_valid,
  input  logic              sub_chan_b,
  input  logic              sub_block_start,
  input  logic              sub_cbit,
  input  logic              chan_sel,
  input  logic [PAGE_W-1:0] page_sel,
  output logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_mask
);
  localparam int NUM_PAGES = BLOCK_BITS / WORD_W;
  localparam int CNT_W     = $clog2(BLOCK_BITS);

  logic [BLOCK_BITS-1:0] shadow_q, block_q, shadow_nx;
  logic [CNT_W-1:0]      idx_q;
  logic                  armed_q, chan_q;

  wire chan_flip = chan_sel != chan_q;
  wire take      = sub_valid && (sub_chan_b == chan_sel) && !chan_flip;
  wire first     = take && sub_block_start;
  wire store     = first || (take && armed_q);
  wire [CNT_W-1:0] pos = first ? '0 : idx_q;
  wire last      = store && (pos == CNT_W'(BLOCK_BITS - 1));

  always_comb begin
    shadow_nx = shadow_q;
    shadow_nx[pos] = sub_cbit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      block_q  <= '0;
      idx_q    <= '0;
      armed_q  <= 1'b0;
      chan_q   <= 1'b0;
    end else begin
      chan_q <= chan_sel;
      if (chan_flip) begin
        idx_q   <= '0;
        armed_q <= 1'b0;
      end else if (store) begin
        shadow_q <= shadow_nx;
        if (last) begin
          block_q <= shadow_nx;
          idx_q   <= '0;
          armed_q <= 1'b0;
        end else begin
          idx_q   <= pos + 1'b1;
          armed_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    rd_mask = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (page_sel == PAGE_W'(p)) begin
        rd_word = block_q[p*WORD_W +: WORD_W];
        rd_mask = '1;
      end
    end
  end
endmodule

// File: rtl/spdif_cstat_capture_chk.sv
module spdif_cstat_capture_chk #(
  parameter int BLOCK_BITS = 192,
  parameter int WORD_W     = 32,
  parameter int PAGE_W     = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sub_valid,
  input logic                      sub_chan_b,
  input logic                      sub_block_start,
  input logic                      chan_sel,
  input logic [PAGE_W-1:0]         page_sel,
  input logic [WORD_W-1:0]         rd_word,
  input logic [WORD_W-1:0]         rd_mask,
  input logic [$clog2(BLOCK_BITS)-1:0] idx_q,
  input logic                      armed_q,
  input logic                      chan_q
);
  localparam int NUM_PAGES = BLOCK_BITS / WORD_W;

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < BLOCK_BITS);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_valid |=> ($stable(page_sel) -> $stable(rd_word)));

  assert_other_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_chan_b != chan_sel && chan_sel == chan_q)
      |=> ($stable(idx_q) && $stable(armed_q)));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && sub_valid && !sub_block_start && chan_sel == chan_q)
      |=> (!armed_q && idx_q == '0));

  assert_chan_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel != chan_q) |=> (!armed_q && idx_q == '0));

  assert_oob_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(page_sel) >= NUM_PAGES) |-> (rd_word == '0 && rd_mask == '0));

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(page_sel) < NUM_PAGES) |-> (rd_mask == '1));
endmodule

bind spdif_cstat_capture spdif_cstat_capture_chk #(
  .BLOCK_BITS(BLOCK_BITS), .WORD_W(WORD_W), .PAGE_W(PAGE_W)
) u_chk (.*);

// File: tb/spdif_cstat_capture_bench.sv
module spdif_cstat_capture_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_valid = 0, sub_chan_b = 0, sub_block_start = 0, sub_cbit = 0, chan_sel = 0;
  logic [2:0]  page_sel = '0;
  logic [31:0] rd_word, rd_mask;

  int checks = 0, failures = 0;
  logic [191:0] exp_blk = '0, m_sh = '0;
  int  m_idx = 0;
  bit  m_armed = 0;

  always #4 clk = ~clk;

  spdif_cstat_capture u_spdif_cstat_capture (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_chan_b(sub_chan_b),
    .sub_block_start(sub_block_start), .sub_cbit(sub_cbit), .chan_sel(chan_sel),
    .page_sel(page_sel), .rd_word(rd_word), .rd_mask(rd_mask));

  function automatic logic [31:0] exp_word(int p);
    if (p > 5) return 32'h0;
    return exp_blk[p*32 +: 32];
  endfunction

  function automatic logic [31:0] exp_mask(int p);
    return (p > 5) ? 32'h0 : 32'hFFFF_FFFF;
  endfunction

  task automatic check_pages(string req);
    for (int p = 0; p < 8; p++) begin
      page_sel = 3'(p);
      #1;
      checks++;
      if (rd_word !== exp_word(p) || rd_mask !== exp_mask(p)) begin
        failures++;
        $display("FAIL %s page %0d word=%h mask=%h expected word=%h mask=%h",
                 req, p, rd_word, rd_mask, exp_word(p), exp_mask(p));
      end
    end
  endtask

  task automatic send(bit chb, bit start, bit cb);
    @(negedge clk);
    sub_valid = 1; sub_chan_b = chb; sub_block_start = start; sub_cbit = cb;
    @(negedge clk);
    sub_valid = 0; sub_block_start = 0;
    if (chb == chan_sel) begin
      if (start) begin m_idx = 0; m_armed = 1; end
      if (m_armed) begin
        m_sh[m_idx] = cb;
        if (m_idx == 191) begin exp_blk = m_sh; m_armed = 0; m_idx = 0; end
        else m_idx++;
      end
    end
  endtask

  task automatic set_chan(bit c);
    @(negedge clk);
    sub_valid = 1; sub_chan_b = c; sub_block_start = 1; sub_cbit = 1;
    chan_sel = c;
    @(negedge clk);
    sub_valid = 0; sub_block_start = 0;
    m_armed = 0; m_idx = 0;
  endtask

  task automatic frames(int n, bit start_first, bit both);
    for (int i = 0; i < n; i++) begin
      bit st = start_first && (i == 0);
      send(1'b0, st, 1'($urandom));
      if (both) send(1'b1, st, 1'($urandom));
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5D1F_0C3A));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_pages("R1");

    // R2 R3 R4: full block on A with B interleaved, mid-block read holds old
    frames(100, 1, 1);
    check_pages("R4");
    frames(92, 0, 1);
    check_pages("R2/R3");

    // R3: directed pattern, single byte markers
    @(negedge clk);
    for (int k = 0; k < 192; k++) send(1'b0, k == 0, (k % 8 == 0) || (k == 191));
    check_pages("R3");

    // R7 then channel B capture
    frames(60, 1, 1);
    set_chan(1'b1);
    for (int k = 0; k < 140; k++) send(1'b1, 0, 1'($urandom));
    check_pages("R7");
    frames(192, 1, 1);
    check_pages("R2");

    // R5: early restart
    frames(50, 1, 1);
    frames(192, 1, 1);
    check_pages("R5");

    // R6: trailing bits with no start
    frames(250, 0, 1);
    check_pages("R6");

    // R7 back to A mid-block, continue without start
    set_chan(1'b0);
    frames(100, 1, 0);
    set_chan(1'b1);
    set_chan(1'b0);
    frames(92, 0, 0);
    check_pages("R7");

    // random mix of restarts and channel switches
    for (int r = 0; r < 12; r++) begin
      if ($urandom_range(3) == 0) set_chan(1'($urandom));
      frames($urandom_range(20, 120), 1, 1);
      frames($urandom_range(0, 150), $urandom_range(4) == 0, 1);
      check_pages("R4/R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule